// File: doc/BRIEF.md
# Wrapping Interval Clock with Overflow Flag

This block is a free-running interval clock for a small processor. While it runs, a prescaler divides the system clock down to a fixed tick rate, nominally one thousand ticks per second. Every tick adds one to a counter word that wraps around at its full width. When an increment carries the counter from all ones back to zero, a sticky overflow flag is raised.

The processor drives the block with single-cycle command strobes. A command word carries three independent bits: halt, go and clear-flag. The processor can also test the flag with a skip query. It can read the counter at any time and load it with a value. Loading a value N below the wrap point gives an overflow N ticks after the clock starts, so software uses the load to set the length of an interval. A go command sent to a clock that is already running is ignored, so it does not disturb the phase of the tick in progress.

Top module: `tick_wrap_timer`

## Requirements
- R1: After a synchronous reset the counter reads zero, the overflow flag is clear, the clock is stopped and the skip answer is 0.
- R2: While running, the counter adds one every DIV = CLK_HZ/TICK_HZ system clocks. After a go command from the stopped state, the first increment appears DIV clock edges after the edge that took the command.
- R3: The counter wraps from all ones to zero, and the overflow flag is set exactly when an increment produces that wrap.
- R4: The halt command (command bit 0) stops ticking on the next edge, and the counter then holds its value.
- R5: A go command (command bit 1) while the clock is already running is ignored: the clock keeps running and the tick phase is not reset.
- R6: When halt and go are both set in one command, halt is applied first. The clock ends up running, with a fresh prescaler phase, so the next tick comes DIV edges later.
- R7: The clear-flag command (command bit 2) clears the overflow flag on the next edge. If a wrap happens in the same cycle, the set wins.
- R8: The skip answer is registered. One edge after a cycle with the skip query asserted, it reads 1 if the flag was set during that cycle, and 0 otherwise.
- R9: A counter load takes effect on the next edge and has priority over a tick in the same cycle. That tick is dropped, and it can neither increment the counter nor set the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Strobe qualifying the command bits |
| cmd_bits | input | 3 | bit0 halt, bit1 go, bit2 clear flag |
| load_en | input | 1 | Load the counter this cycle |
| load_val | input | CNT_W | Value to load |
| skip_query | input | 1 | Ask whether the overflow flag is set |
| count_o | output | CNT_W | Current counter value |
| ovf_o | output | 1 | Overflow flag |
| running_o | output | 1 | Clock is ticking |
| skip_o | output | 1 | Registered answer to the skip query |

## Verification
A bad prescaler phase shows on count_o as an increment that comes at the wrong edge, within one tick period of the fault. This is why the bench compares the counter on every clock. A wrong run state shows within DIV cycles, as ticks that are missing or extra. A stuck or stray flag bit shows immediately on ovf_o, and one cycle later on skip_o. The load-versus-tick collision is forced by holding a load of all ones across a whole tick period: any tick that leaks through shows at once as a zero count or a set flag.

// File: rtl/wc_pkg.sv
package wc_pkg;
  localparam int CMD_W   = 3;
  localparam int BIT_HLT = 0;
  localparam int BIT_GO  = 1;
  localparam int BIT_CLR = 2;

  typedef struct packed {
    logic clr;
    logic go;
    logic hlt;
  } cmd_t;
endpackage

// File: rtl/wc_prescaler.sv
module wc_prescaler #(
  parameter int DIV = 1000
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  input  logic restart,
  output logic tick
);
  localparam int PW = (DIV > 1) ? $clog2(DIV) : 1;

  generate
    if (DIV <= 1) begin : g_bypass
      assign tick = run;
    end else begin : g_div
      logic [PW-1:0] ph_q;
      logic          at_end;
      assign at_end = (ph_q == PW'(DIV - 1));
      assign tick   = run & at_end;
      always_ff @(posedge clk) begin
        if (rst || !run || restart) begin
          ph_q <= '0;
        end else if (at_end) begin
          ph_q <= '0;
        end else begin
          ph_q <= ph_q + 1'b1;
        end
      end
    end
  endgenerate
endmodule

// File: rtl/wc_counter.sv
module wc_counter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         ld,
  input  logic [W-1:0] ld_val,
  input  logic         tick,
  output logic [W-1:0] cnt,
  output logic         wrap
);
  logic [W-1:0] cnt_q;

  // a tick that collides with a load is discarded
  assign wrap = tick & ~ld & (&cnt_q);
  assign cnt  = cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (ld) begin
      cnt_q <= ld_val;
    end else if (tick) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/wc_control.sv
module wc_control
  import wc_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic cmd_valid,
  input  cmd_t cmd,
  input  logic wrap,
  input  logic query,
  output logic run,
  output logic restart,
  output logic ovf,
  output logic skip
);
  logic run_q, ovf_q, skip_q;
  logic halt_now, go_now, clr_now;

  assign halt_now = cmd_valid & cmd.hlt;
  assign go_now   = cmd_valid & cmd.go;
  assign clr_now  = cmd_valid & cmd.clr;
  // halt is applied before go, so go only restarts if stopped or just halted
  assign restart  = go_now & (~run_q | halt_now);

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q  <= 1'b0;
      ovf_q  <= 1'b0;
      skip_q <= 1'b0;
    end else begin
      if (restart)       run_q <= 1'b1;
      else if (halt_now) run_q <= 1'b0;

      if (wrap)         ovf_q <= 1'b1;
      else if (clr_now) ovf_q <= 1'b0;

      skip_q <= query & ovf_q;
    end
  end

  assign run  = run_q;
  assign ovf  = ovf_q;
  assign skip = skip_q;
endmodule

// File: rtl/tick_wrap_timer.sv
module tick_wrap_timer
  import wc_pkg::*;
#(
  parameter int CLK_HZ  = 1000000,
  parameter int TICK_HZ = 1000,
  parameter int CNT_W   = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cmd_valid,
  input  logic [CMD_W-1:0] cmd_bits,
  input  logic             load_en,
  input  logic [CNT_W-1:0] load_val,
  input  logic             skip_query,
  output logic [CNT_W-1:0] count_o,
  output logic             ovf_o,
  output logic             running_o,
  output logic             skip_o
);
  localparam int DIV = (CLK_HZ / TICK_HZ < 1) ? 1 : CLK_HZ / TICK_HZ;

  logic tick_w, wrap_w, restart_w, run_w;
  cmd_t cmd_w;

  assign cmd_w = cmd_t'(cmd_bits);

  wc_control u_ctl (
    .clk       (clk),
    .rst       (rst),
    .cmd_valid (cmd_valid),
    .cmd       (cmd_w),
    .wrap      (wrap_w),
    .query     (skip_query),
    .run       (run_w),
    .restart   (restart_w),
    .ovf       (ovf_o),
    .skip      (skip_o)
  );

  wc_prescaler #(.DIV(DIV)) u_pre (
    .clk     (clk),
    .rst     (rst),
    .run     (run_w),
    .restart (restart_w),
    .tick    (tick_w)
  );

  wc_counter #(.W(CNT_W)) u_cnt (
    .clk    (clk),
    .rst    (rst),
    .ld     (load_en),
    .ld_val (load_val),
    .tick   (tick_w),
    .cnt    (count_o),
    .wrap   (wrap_w)
  );

  assign running_o = run_w;
endmodule

// File: rtl/wc_checker.sv
module wc_checker
  import wc_pkg::*;
#(
  parameter int W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             cmd_valid,
  input logic [CMD_W-1:0] cmd_bits,
  input logic             load_en,
  input logic [W-1:0]     load_val,
  input logic             skip_query,
  input logic             tick,
  input logic [W-1:0]     count_o,
  input logic             ovf_o,
  input logic             running_o,
  input logic             skip_o
);
  p_reset_state_r1: assert property (@(posedge clk)
    rst |=> (!running_o && !ovf_o && count_o == '0 && !skip_o));

  p_flag_rise_r3: assert property (@(posedge clk) disable iff (rst)
    $rose(ovf_o) |-> (count_o == '0));

  p_stopped_hold_r4: assert property (@(posedge clk) disable iff (rst)
    (!running_o && !load_en) |=> $stable(count_o));

  p_go_ignored_r5: assert property (@(posedge clk) disable iff (rst)
    (running_o && cmd_valid && cmd_bits[BIT_GO] && !cmd_bits[BIT_HLT]) |=> running_o);

  p_clear_r7: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_bits[BIT_CLR] && !(tick && !load_en && (&count_o))) |=> !ovf_o);

  p_skip_r8: assert property (@(posedge clk) disable iff (rst)
    skip_o |-> $past(skip_query && ovf_o));

  p_load_r9: assert property (@(posedge clk) disable iff (rst)
    load_en |=> (count_o == $past(load_val)));
endmodule

bind tick_wrap_timer wc_checker #(.W(CNT_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .cmd_valid  (cmd_valid),
  .cmd_bits   (cmd_bits),
  .load_en    (load_en),
  .load_val   (load_val),
  .skip_query (skip_query),
  .tick       (tick_w),
  .count_o    (count_o),
  .ovf_o      (ovf_o),
  .running_o  (running_o),
  .skip_o     (skip_o)
);

// File: tb/sim_tick_wrap_timer.sv
module sim_tick_wrap_timer;
  localparam int CLK_PERIOD = 10;
  localparam int CLK_HZ  = 8000;
  localparam int TICK_HZ = 1000;
  localparam int DIV     = CLK_HZ / TICK_HZ;
  localparam int W       = 16;
  localparam int MODV    = 1 << W;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         cmd_valid = 1'b0;
  logic [2:0]   cmd_bits = '0;
  logic         load_en = 1'b0;
  logic [W-1:0] load_val = '0;
  logic         skip_query = 1'b0;
  logic [W-1:0] count_o;
  logic         ovf_o, running_o, skip_o;

  int n_vec = 0;
  int n_bad = 0;
  int cyc   = 0;
  bit done  = 1'b0;

  // behavioural reference state
  int m_cnt = 0, m_phase = 0;
  bit m_run = 0, m_ovf = 0, m_skip = 0;

  tick_wrap_timer #(.CLK_HZ(CLK_HZ), .TICK_HZ(TICK_HZ), .CNT_W(W)) u0 (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_bits(cmd_bits),
    .load_en(load_en), .load_val(load_val), .skip_query(skip_query),
    .count_o(count_o), .ovf_o(ovf_o), .running_o(running_o), .skip_o(skip_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    bit tk, wr, fresh, hl, go, cl;
    if (rst) begin
      m_cnt = 0; m_phase = 0; m_run = 0; m_ovf = 0; m_skip = 0;
    end else begin
      hl = cmd_valid && cmd_bits[0];
      go = cmd_valid && cmd_bits[1];
      cl = cmd_valid && cmd_bits[2];
      tk = m_run && (m_phase == DIV - 1);
      wr = tk && !load_en && (m_cnt == MODV - 1);
      fresh = go && (!m_run || hl);
      m_skip = skip_query && m_ovf;
      if (wr) m_ovf = 1;
      else if (cl) m_ovf = 0;
      if (load_en) m_cnt = int'(load_val);
      else if (tk) m_cnt = (m_cnt + 1) % MODV;
      if (!m_run || fresh || tk) m_phase = 0;
      else m_phase = m_phase + 1;
      if (fresh) m_run = 1;
      else if (hl) m_run = 0;
    end
  end

  task automatic check(input string tag, input int act, input int exp);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h at cycle %0d", tag, act, exp, cyc);
    end
  endtask

  task automatic step(input int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      #1;
      cyc++;
      check("R2 R3 R9 count vs model", int'(count_o), m_cnt);
      check("R3 R7 flag vs model", int'(ovf_o), int'(m_ovf));
      check("R4 R5 R6 run vs model", int'(running_o), int'(m_run));
      check("R8 skip vs model", int'(skip_o), int'(m_skip));
    end
  endtask

  task automatic send(input logic [2:0] c);
    cmd_valid = 1'b1; cmd_bits = c;
    step(1);
    cmd_valid = 1'b0; cmd_bits = '0;
  endtask

  initial begin
    int c0;
    step(3);
    rst = 1'b0;
    step(1);
    // R1 reset state
    check("R1 count after reset", int'(count_o), 0);
    check("R1 flag after reset", int'(ovf_o), 0);
    check("R1 stopped after reset", int'(running_o), 0);

    // R2 start from stopped: five ticks within 40 edges after command
    send(3'b010);
    step(40);
    check("R2 count after 40 edges", int'(count_o), 5);

    // R5 go while running leaves phase alone
    step(3);
    send(3'b010);
    check("R5 still running", int'(running_o), 1);
    step(20);

    // R4 halt holds counter
    send(3'b001);
    c0 = int'(count_o);
    step(20);
    check("R4 held count", int'(count_o), c0);
    check("R4 stopped", int'(running_o), 0);

    // R3 preset near wrap, overflow after three ticks
    load_en = 1'b1; load_val = 16'hFFFD;
    step(1);
    load_en = 1'b0;
    send(3'b010);
    step(3*DIV - 1);
    check("R3 no flag before wrap", int'(ovf_o), 0);
    check("R3 count before wrap", int'(count_o), 16'hFFFF);
    step(1);
    check("R3 count wrapped", int'(count_o), 0);
    check("R3 flag set", int'(ovf_o), 1);

    // R8 skip query
    skip_query = 1'b1;
    step(1);
    skip_query = 1'b0;
    check("R8 skip answers set flag", int'(skip_o), 1);
    step(1);
    check("R8 skip drops without query", int'(skip_o), 0);

    // R7 clear flag
    send(3'b100);
    check("R7 flag cleared", int'(ovf_o), 0);
    skip_query = 1'b1;
    step(1);
    skip_query = 1'b0;
    step(1);
    check("R8 skip with clear flag", int'(skip_o), 0);

    // R6 halt and go together: fresh phase
    step(5);
    send(3'b011);
    c0 = int'(count_o);
    check("R6 running after combined", int'(running_o), 1);
    step(DIV - 1);
    check("R6 no tick before full period", int'(count_o), c0);
    step(1);
    check("R6 tick after full period", int'(count_o), (c0 + 1) % MODV);

    // R9 load held across a full tick period: ticks dropped, no wrap
    load_en = 1'b1; load_val = 16'hFFFF;
    step(DIV + 1);
    load_en = 1'b0;
    check("R9 load wins over tick", int'(count_o), 16'hFFFF);
    check("R9 no flag from dropped tick", int'(ovf_o), 0);
    step(2*DIV);
    check("R3 wrap after load released", int'(ovf_o), 1);

    send(3'b001);
    step(4);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule